// File: doc/BRIEF.md
# Saturating Fractional Multiply-Accumulate Unit

This unit serves the fixed-point arithmetic of a speech-coding datapath. Each cycle it takes two signed 16-bit fractional operands and an operation select. It forms their product and doubles it to reach a 32-bit fractional value. In the next cycle it adds that value to a signed 32-bit accumulator, or subtracts it, and saturates at both steps. A 32-bit result and an overflow flag come out at the end of that second cycle.

The two operands and the select are registered at the first clock edge. The accumulator is not stored inside the unit. The surrounding datapath drives it during the following cycle, and the result depends on it combinationally in that cycle. A new operation may start on every cycle. The datapath registers have no reset, so the outputs carry no meaning until one operation has passed the first edge.

Saturation of the product and saturation of the sum are resolved side by side. One adder takes the real doubled product and a second adder takes the saturated product. A priority select then picks between the two sums and the two saturation limits. Subtraction reuses the same adders: the second operand is inverted and the carry-in is driven high.

Top module: `fmac_unit`

## Requirements
- R1: The product term equals twice the signed product of the two operands (for example 0x4000 times 0x4000 gives 0x20000000, and -1 times 1 gives -2).
- R2: When both operands are -32768, the product term is replaced by 0x7FFFFFFF and the overflow flag is raised, whatever the accumulator holds.
- R3: With op_i = 0 (accumulate), the result is accumulator plus product term whenever that sum lies within the signed 32-bit range.
- R4: With op_i = 1 (subtract), the result is accumulator minus product term whenever that difference lies within the signed 32-bit range.
- R5: When the exact sum or difference exceeds the largest positive value, the result is 0x7FFFFFFF and the overflow flag is 1.
- R6: When the exact sum or difference falls below the most negative value, the result is 0x80000000 and the overflow flag is 1.
- R7: After a multiply saturation, the accumulator is combined with the saturated term: acc + 0x7FFFFFFF on accumulate, acc - 0x7FFFFFFF on subtract. This value is saturated again when out of range (acc -5 accumulate gives 0x7FFFFFFA; acc 0 subtract gives 0x80000001; acc -1 subtract gives 0x80000000).
- R8: Operands and the select sampled at one rising edge determine res_o and ovf_o during the following cycle. The accumulator driven in that cycle feeds the result combinationally, operands changed after the edge do not disturb it, and a new operation is accepted on every edge.
- R9: The overflow flag is 0 whenever neither the multiply nor the add/subtract saturates, including with the accumulator at either 32-bit extreme and a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| op_i | input | 1 | Operation select: 0 accumulate, 1 subtract; sampled with the operands |
| opa_i | input | 16 | Signed fractional multiplicand |
| opb_i | input | 16 | Signed fractional multiplier |
| acc_i | input | 32 | Signed accumulator, driven in the cycle after the operands |
| res_o | output | 32 | Saturated signed result |
| ovf_o | output | 1 | Overflow: multiply saturation or add/subtract saturation |

## Verification
The bench builds the unit with its default 16-bit operand width, which makes the accumulator 32 bits wide. At that width the single multiply saturation case is -32768 times -32768. The 32-bit limits can also be driven directly as accumulator values, so every branch of the priority select can be reached by directed vectors, including the corner pairs mixed with accumulators at both extremes, -1, 0 and -5. Random vectors are biased toward extreme operands and run back to back against a wide-integer model of saturated multiply followed by saturated add or subtract.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

    // default operand width of the fractional multiplier
    localparam int unsigned FMAC_DW = 16;

    // operation encoding on op_i
    typedef enum logic {
        FMAC_ACC = 1'b0,
        FMAC_SUB = 1'b1
    } fmac_op_e;

endpackage

// File: rtl/fmac_prod_stage.sv
module fmac_prod_stage #(
    parameter int unsigned DW = fmac_pkg::FMAC_DW
) (
    input  logic            clk_i,
    input  logic            op_i,
    input  logic [DW-1:0]   opa_i,
    input  logic [DW-1:0]   opb_i,
    output logic [2*DW-1:0] prod_o,
    output logic            mul_ovf_o,
    output logic            sub_o
);

    localparam int unsigned AW = 2 * DW;
    // raw product that would double past the positive limit
    localparam logic [AW-1:0] RAW_LIMIT = {2'b01, {(AW-2){1'b0}}};

    typedef struct packed {
        logic [AW-1:0] prod;
        logic          mul_ovf;
        logic          sub;
    } stage_t;

    stage_t             st_d, st_q;
    logic signed [AW-1:0] raw;
    logic [AW-1:0]        dbl;

    always_comb begin
        raw         = $signed(opa_i) * $signed(opb_i);
        dbl         = {raw[AW-2:0], 1'b0};
        st_d.sub    = (fmac_pkg::fmac_op_e'(op_i) == fmac_pkg::FMAC_SUB);
        st_d.mul_ovf = (raw == RAW_LIMIT);
        st_d.prod   = st_d.sub ? ~dbl : dbl;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign prod_o    = st_q.prod;
    assign mul_ovf_o = st_q.mul_ovf;
    assign sub_o     = st_q.sub;

endmodule

// File: rtl/fmac_add_ovf.sv
module fmac_add_ovf #(
    parameter int unsigned AW = 2 * fmac_pkg::FMAC_DW
) (
    input  logic [AW-1:0] a_i,
    input  logic [AW-1:0] b_i,
    input  logic          ci_i,
    output logic [AW-1:0] sum_o,
    output logic          ovf_o
);

    always_comb begin
        sum_o = a_i + b_i + AW'(ci_i);
        // like-signed inputs whose sum changes sign
        ovf_o = (a_i[AW-1] == b_i[AW-1]) && (sum_o[AW-1] != a_i[AW-1]);
    end

endmodule

// File: rtl/fmac_sum_select.sv
module fmac_sum_select #(
    parameter int unsigned AW = 2 * fmac_pkg::FMAC_DW
) (
    input  logic [AW-1:0] acc_i,
    input  logic [AW-1:0] prod_i,
    input  logic          mul_ovf_i,
    input  logic          sub_i,
    output logic [AW-1:0] res_o,
    output logic          ovf_o
);

    localparam int unsigned NCAND = 2;
    localparam logic [AW-1:0] POS_LIM = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] NEG_LIM = {1'b1, {(AW-1){1'b0}}};

    logic [AW-1:0] cand_b [NCAND];
    logic [AW-1:0] cand_s [NCAND];
    logic          cand_v [NCAND];

    // candidate 0: real product term, candidate 1: saturated product term
    assign cand_b[0] = prod_i;
    assign cand_b[1] = sub_i ? ~POS_LIM : POS_LIM;

    for (genvar g = 0; g < NCAND; g++) begin : g_cand
        fmac_add_ovf #(.AW(AW)) u_add (
            .a_i   (acc_i),
            .b_i   (cand_b[g]),
            .ci_i  (sub_i),
            .sum_o (cand_s[g]),
            .ovf_o (cand_v[g])
        );
    end

    always_comb begin
        ovf_o = mul_ovf_i | cand_v[0];
        if (!ovf_o) begin
            res_o = cand_s[0];
        end else if (mul_ovf_i && !cand_v[1]) begin
            res_o = cand_s[1];
        end else if (!acc_i[AW-1]) begin
            res_o = POS_LIM;
        end else begin
            res_o = NEG_LIM;
        end
    end

endmodule

// File: rtl/fmac_unit.sv
module fmac_unit #(
    parameter int unsigned DW = fmac_pkg::FMAC_DW
) (
    input  logic            clk_i,
    input  logic            op_i,
    input  logic [DW-1:0]   opa_i,
    input  logic [DW-1:0]   opb_i,
    input  logic [2*DW-1:0] acc_i,
    output logic [2*DW-1:0] res_o,
    output logic            ovf_o
);

    localparam int unsigned AW = 2 * DW;

    logic [AW-1:0] prod_q;
    logic          mul_ovf_q;
    logic          sub_q;

    fmac_prod_stage #(.DW(DW)) u_prod (
        .clk_i     (clk_i),
        .op_i      (op_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .prod_o    (prod_q),
        .mul_ovf_o (mul_ovf_q),
        .sub_o     (sub_q)
    );

    fmac_sum_select #(.AW(AW)) u_sel (
        .acc_i     (acc_i),
        .prod_i    (prod_q),
        .mul_ovf_i (mul_ovf_q),
        .sub_i     (sub_q),
        .res_o     (res_o),
        .ovf_o     (ovf_o)
    );

endmodule

// File: rtl/fmac_unit_chk.sv
module fmac_unit_chk #(
    parameter int unsigned DW = fmac_pkg::FMAC_DW
) (
    input logic            clk_i,
    input logic            op_i,
    input logic [DW-1:0]   opa_i,
    input logic [DW-1:0]   opb_i,
    input logic [2*DW-1:0] acc_i,
    input logic [2*DW-1:0] res_o,
    input logic            ovf_o
);

    localparam int unsigned AW = 2 * DW;
    localparam longint MAXL = (64'sd1 <<< (AW - 1)) - 64'sd1;
    localparam longint MINL = -MAXL - 64'sd1;

    logic                 primed = 1'b0;
    logic signed [DW-1:0] a_q, b_q;
    logic                 op_q;
    logic                 corner;
    longint               acc_l, res_l, term_l, exact_l, sat_l;

    always_ff @(posedge clk_i) begin
        primed <= 1'b1;
        a_q    <= opa_i;
        b_q    <= opb_i;
        op_q   <= op_i;
    end

    always_comb begin
        corner  = (a_q == {1'b1, {(DW-1){1'b0}}}) && (b_q == {1'b1, {(DW-1){1'b0}}});
        acc_l   = longint'($signed(acc_i));
        res_l   = longint'($signed(res_o));
        term_l  = 64'sd2 * longint'(a_q) * longint'(b_q);
        exact_l = op_q ? acc_l - term_l : acc_l + term_l;
        sat_l   = op_q ? acc_l - MAXL : acc_l + MAXL;
    end

    // R3 / R4 / R9: without overflow the result is the exact sum
    p_exact_r3: assert property (@(posedge clk_i) disable iff (!primed)
        !ovf_o |-> (res_l == exact_l));

    // R2: the multiply corner always raises the flag
    p_mul_flag_r2: assert property (@(posedge clk_i) disable iff (!primed)
        corner |-> ovf_o);

    // R5: positive saturation without a multiply corner
    p_pos_sat_r5: assert property (@(posedge clk_i) disable iff (!primed)
        (ovf_o && !corner && !acc_i[AW-1]) |-> (res_l == MAXL));

    // R6: negative saturation without a multiply corner
    p_neg_sat_r6: assert property (@(posedge clk_i) disable iff (!primed)
        (ovf_o && !corner && acc_i[AW-1]) |-> (res_l == MINL));

    // R7: corner with an in-range second sum uses the saturated term
    p_sat_term_r7: assert property (@(posedge clk_i) disable iff (!primed)
        (corner && sat_l <= MAXL && sat_l >= MINL) |-> (res_l == sat_l));

endmodule

bind fmac_unit fmac_unit_chk #(.DW(DW)) u_chk (
    .clk_i (clk_i),
    .op_i  (op_i),
    .opa_i (opa_i),
    .opb_i (opb_i),
    .acc_i (acc_i),
    .res_o (res_o),
    .ovf_o (ovf_o)
);

// File: tb/fmac_unit_test.sv
`timescale 1ns/1ps
module fmac_unit_test;

    localparam int unsigned DW = 16;
    localparam int unsigned AW = 32;
    localparam longint MAXL = 64'sd2147483647;
    localparam longint MINL = -64'sd2147483648;

    logic                 clk = 1'b0;
    logic                 op_r = 1'b0;
    logic signed [DW-1:0] a_r = '0;
    logic signed [DW-1:0] b_r = '0;
    logic signed [AW-1:0] acc_r = '0;
    logic [AW-1:0]        res;
    logic                 ovf;

    int n_vec  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fmac_unit #(.DW(DW)) uut (
        .clk_i (clk),
        .op_i  (op_r),
        .opa_i (a_r),
        .opb_i (b_r),
        .acc_i (acc_r),
        .res_o (res),
        .ovf_o (ovf)
    );

    // behavioural model: saturated doubling multiply, then saturated add/sub
    function automatic void model(input logic op, input logic signed [DW-1:0] a,
                                  input logic signed [DW-1:0] b, input logic signed [AW-1:0] acc,
                                  output logic [AW-1:0] r, output logic v);
        longint p, s;
        logic   m;
        p = longint'(a) * longint'(b);
        m = (p == 64'sh40000000);
        p = m ? MAXL : 2 * p;
        s = op ? longint'(acc) - p : longint'(acc) + p;
        v = m;
        if (s > MAXL) begin s = MAXL; v = 1'b1; end
        if (s < MINL) begin s = MINL; v = 1'b1; end
        r = s[AW-1:0];
    endfunction

    task automatic compare(input string tag, input logic [AW-1:0] er, input logic ev);
        n_vec++;
        if (res !== er || ovf !== ev) begin
            n_fail++;
            $display("FAIL %s: res=%h ovf=%b expected res=%h ovf=%b", tag, res, ovf, er, ev);
        end
    endtask

    // issue one operation; called at a negative edge
    task automatic issue(input logic op, input logic signed [DW-1:0] a,
                         input logic signed [DW-1:0] b, input logic signed [AW-1:0] acc,
                         input string tag);
        logic [AW-1:0] er;
        logic          ev;
        model(op, a, b, acc, er, ev);
        op_r = op; a_r = a; b_r = b;
        @(posedge clk);
        #1 acc_r = acc;
        @(negedge clk);
        compare(tag, er, ev);
        // R8: later operand changes must not disturb the current result
        op_r = ~op; a_r = ~a; b_r = b ^ 16'h5A5A;
        #1 compare("R8 hold", er, ev);
    endtask

    function automatic logic signed [DW-1:0] pick16();
        int unsigned k = $urandom % 8;
        case (k)
            0: return 16'sh8000;
            1: return 16'sh7FFF;
            2: return 16'sh0000;
            3: return -16'sd1;
            default: return $urandom;
        endcase
    endfunction

    function automatic logic signed [AW-1:0] pick32();
        int unsigned k = $urandom % 8;
        case (k)
            0: return 32'sh7FFFFFFF;
            1: return 32'sh80000000;
            2: return 32'sh7FFF0000;
            3: return -32'sd2147418112;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        @(negedge clk);
        // R1: doubling
        issue(1'b0, 16'sh4000, 16'sh4000, 32'sd0, "R1 half*half");
        issue(1'b0, -16'sd1, 16'sd1, 32'sd0, "R1 neg");
        // R2: multiply corner
        issue(1'b0, 16'sh8000, 16'sh8000, 32'sd0, "R2 corner acc0");
        // R3 / R4
        issue(1'b0, 16'sd3, 16'sd5, 32'sd1000, "R3 accumulate");
        issue(1'b1, 16'sd3, 16'sd5, 32'sd1000, "R4 subtract");
        issue(1'b1, 16'sh8000, 16'sh7FFF, 32'sd0, "R4 subtract negative term");
        // R5 / R6
        issue(1'b0, 16'sd1, 16'sd1, 32'sh7FFFFFFF, "R5 add at max");
        issue(1'b1, 16'sh8000, 16'sh7FFF, 32'sh7FFFFFF0, "R5 subtract to max");
        issue(1'b1, 16'sd1, 16'sd1, 32'sh80000000, "R6 sub at min");
        issue(1'b0, -16'sd1, 16'sd1, 32'sh80000000, "R6 add at min");
        // R7: corner combined with accumulator
        issue(1'b0, 16'sh8000, 16'sh8000, -32'sd5, "R7 corner acc -5");
        issue(1'b1, 16'sh8000, 16'sh8000, -32'sd1, "R7 corner sub acc -1");
        issue(1'b1, 16'sh8000, 16'sh8000, 32'sd0, "R7 corner sub acc 0");
        issue(1'b0, 16'sh8000, 16'sh8000, 32'sh80000000, "R7 corner add acc min");
        issue(1'b0, 16'sh8000, 16'sh8000, 32'sh7FFFFFFF, "R5 corner add acc max");
        issue(1'b1, 16'sh8000, 16'sh8000, 32'sh80000000, "R6 corner sub acc min");
        // R9: zero product at both extremes
        issue(1'b0, 16'sd0, 16'sh7FFF, 32'sh80000000, "R9 zero add min");
        issue(1'b1, 16'sh8000, 16'sd0, 32'sh7FFFFFFF, "R9 zero sub max");
        issue(1'b1, 16'sd0, 16'sd0, 32'sh80000000, "R9 zero sub min");
        // R8 with random back-to-back traffic, also covering R3..R6
        for (int i = 0; i < 3000; i++) begin
            issue(1'($urandom), pick16(), pick16(), pick32(), "R8 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule